// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block is the register front end of an I/O interrupt controller. Software reaches it through a small memory-mapped window that holds only two live offsets: a select register and a data window. The select value picks an indirect target: a 4-bit controller ID, a read-only version word, an arbitration-ID alias of the ID, or one half of a 64-bit redirection entry. There is one entry per interrupt input pin. Accesses may be byte, halfword or word wide. Narrow write data is zero-extended, and narrow reads return the low bytes of the selected word.

The fields of every entry are decoded and driven out continuously to the interrupt delivery logic: vector, delivery mode, destination mode, polarity, remote-IRR, trigger type, mask and destination. The delivery logic sets and clears the remote-IRR bit of an entry through a side port. Each accepted entry write raises a one-cycle pulse that carries the entry index, so the delivery logic can re-evaluate that pin.

Every bus access completes in the cycle it is presented. Read data is registered: it appears on `bus_rdata` in the cycle after the read and holds there until the next read that the block accepts.

Top module: `ioredir_regfile`

## Requirements
- R1: An access whose address is below BASE or at or above BASE+WIN_LEN (defaults 0xFEC00000 and 0x100) changes no state and leaves `bus_rdata` unchanged.
- R2: Inside the window only address bits 7:0 are decoded. Offset 0x00 is the select register and offset 0x10 is the data window. A read at any other offset returns zero, and a write there is ignored.
- R3: A write to the select register keeps only the low 8 bits of the data. A read of the select register returns the stored 8 bits, zero-extended.
- R4: Select index 0x01 reads as (PINS−1) in bits 23:16 and 0x11 in bits 7:0, which is 0x00170011 for 24 pins. Writes to this index are ignored.
- R5: Select index 0x00 is the ID. It keeps 4 bits, taken from data bits 27:24 on a write and returned in bits 27:24 on a read. Index 0x02 reads the same value, and writes to index 0x02 are ignored.
- R6: A select value S of 0x10 or more addresses entry (S−0x10)>>1. An odd S accesses entry bits 63:32 and an even S accesses bits 31:0.
- R7: A select value that names no storage reads as 0xFFFFFFFF. This covers 0x03 to 0x0F and any entry index at or beyond PINS. A write to such a select value is dropped and raises no pulse.
- R8: A write to the low half of an entry stores the data and forces remote-IRR (bit 14) to 0. A write to the high half leaves remote-IRR unchanged.
- R9: When `irr_upd_vld` is high and `irr_upd_idx` is below PINS, that entry's remote-IRR takes the value of `irr_upd_val`. An index at or beyond PINS is ignored. If a low-half software write hits the same entry in the same cycle, the software write wins and the bit becomes 0.
- R10: Reset sets every entry to 0x0000000000010000 (only the mask bit, bit 16, set). It also clears the select register, the ID and `bus_rdata`.
- R11: `bus_size` is encoded as 0 = byte, 1 = halfword, 2 or 3 = word. Write data is zero-extended above the access size. Read data keeps only the low 1, 2 or 4 bytes, with the upper bits zero.
- R12: In the cycle after an accepted entry write, `ent_wr_pulse` is high for one cycle and `ent_wr_idx` holds the entry index.
- R13: The exported fields are decoded from this entry layout: vector at bits 7:0, delivery mode at 10:8, destination mode at 11, polarity at 13, remote-IRR at 14, trigger at 15, mask at 16 and destination at 63:56. Bit 12 is stored and read back only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, held between reads |
| irr_upd_vld | input | 1 | Remote-IRR update strobe from delivery logic |
| irr_upd_idx | input | IDX_W | Entry index for the remote-IRR update |
| irr_upd_val | input | 1 | New remote-IRR value |
| ent_vector | output | PINS*8 | Vector of each entry |
| ent_dlv_mode | output | PINS*3 | Delivery mode of each entry |
| ent_dest_mode | output | PINS | Destination mode of each entry |
| ent_polarity | output | PINS | Input polarity of each entry |
| ent_rirr | output | PINS | Remote-IRR status of each entry |
| ent_trigger | output | PINS | Trigger type of each entry (1 = level) |
| ent_mask | output | PINS | Mask bit of each entry |
| ent_dest | output | PINS*8 | Destination of each entry |
| ent_wr_pulse | output | 1 | One-cycle pulse after an entry write |
| ent_wr_idx | output | IDX_W | Index of the entry last written |

## Verification
The properties assume one access at most per cycle, with `bus_valid` low throughout reset and `bus_size` always one of the four defined codes. The stimulus meets this because every access is driven for exactly one cycle from a task, and reset is held with the bus idle. Remote-IRR updates are driven only on chosen cycles, and one test deliberately lines an update up with a low-half write to the same entry. Read-data checks assume `bus_rdata` is sampled in the cycle after the read, so each task samples one full cycle after it presents the access.

// File: rtl/ioredir_pkg.sv
package ioredir_pkg;

    // indirect indices with fixed meaning
    localparam logic [7:0] IX_ID    = 8'h00;
    localparam logic [7:0] IX_VER   = 8'h01;
    localparam logic [7:0] IX_ARB   = 8'h02;
    localparam logic [7:0] IX_TBL0  = 8'h10;

    // redirection entry field positions
    localparam int F_VEC_LSB  = 0;
    localparam int F_DLV_LSB  = 8;
    localparam int F_DMODE    = 11;
    localparam int F_POL      = 13;
    localparam int F_RIRR     = 14;
    localparam int F_TRIG     = 15;
    localparam int F_MASK     = 16;
    localparam int F_DEST_LSB = 56;

    localparam logic [63:0] ENT_RESET = 64'h0000_0000_0001_0000;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_SEL_RD,
        ACC_SEL_WR,
        ACC_WIN_RD,
        ACC_WIN_WR,
        ACC_ZERO_RD
    } acc_kind_e;

    typedef enum logic [2:0] {
        TGT_ID,
        TGT_VER,
        TGT_ARB,
        TGT_ENTRY,
        TGT_NONE
    } tgt_kind_e;

endpackage

// File: rtl/ioredir_decode.sv
module ioredir_decode
    import ioredir_pkg::*;
#(
    parameter int          ADDR_W  = 32,
    parameter logic [31:0] BASE    = 32'hFEC0_0000,
    parameter logic [31:0] WIN_LEN = 32'h0000_0100,
    parameter logic [7:0]  SEL_OFS = 8'h00,
    parameter logic [7:0]  WIN_OFS = 8'h10
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [31:0]       wdata,
    output acc_kind_e         acc,
    output logic [31:0]       wdata_ext,
    output logic [31:0]       size_mask
);

    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] LEN_A  = ADDR_W'(WIN_LEN);

    logic       in_win;
    logic [7:0] ofs;

    assign in_win = (addr >= BASE_A) && ((addr - BASE_A) < LEN_A);
    assign ofs    = addr[7:0];

    always_comb begin
        unique case (size)
            2'd0:    size_mask = 32'h0000_00FF;
            2'd1:    size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    end

    assign wdata_ext = wdata & size_mask;

    always_comb begin
        acc = ACC_NONE;
        if (valid && in_win) begin
            if (ofs == SEL_OFS)
                acc = write ? ACC_SEL_WR : ACC_SEL_RD;
            else if (ofs == WIN_OFS)
                acc = write ? ACC_WIN_WR : ACC_WIN_RD;
            else if (!write)
                acc = ACC_ZERO_RD;
        end
    end

endmodule

// File: rtl/ioredir_target.sv
module ioredir_target
    import ioredir_pkg::*;
#(
    parameter int PINS  = 24,
    parameter int IDX_W = 5
) (
    input  logic [7:0]       sel,
    output tgt_kind_e        tgt,
    output logic [IDX_W-1:0] idx,
    output logic             hi
);

    logic [7:0] raw;

    assign raw = (sel - IX_TBL0) >> 1;
    assign hi  = sel[0];

    always_comb begin
        tgt = TGT_NONE;
        idx = '0;
        if (sel == IX_ID)
            tgt = TGT_ID;
        else if (sel == IX_VER)
            tgt = TGT_VER;
        else if (sel == IX_ARB)
            tgt = TGT_ARB;
        else if ((sel >= IX_TBL0) && (raw < 8'(PINS))) begin
            tgt = TGT_ENTRY;
            idx = raw[IDX_W-1:0];
        end
    end

endmodule

// File: rtl/ioredir_table.sv
module ioredir_table
    import ioredir_pkg::*;
#(
    parameter int PINS  = 24,
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_hi,
    input  logic [31:0]       wr_data,
    input  logic              rirr_vld,
    input  logic [IDX_W-1:0]  rirr_idx,
    input  logic              rirr_val,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_hi,
    output logic [31:0]       rd_data,
    output logic [PINS*8-1:0] f_vector,
    output logic [PINS*3-1:0] f_dlv_mode,
    output logic [PINS-1:0]   f_dest_mode,
    output logic [PINS-1:0]   f_polarity,
    output logic [PINS-1:0]   f_rirr,
    output logic [PINS-1:0]   f_trigger,
    output logic [PINS-1:0]   f_mask,
    output logic [PINS*8-1:0] f_dest
);

    logic [PINS*64-1:0] ent_flat;

    for (genvar i = 0; i < PINS; i++) begin : g_ent
        logic [63:0] q;
        logic        hit_wr;
        logic        hit_rirr;

        assign hit_wr   = wr_en && (wr_idx == IDX_W'(i));
        assign hit_rirr = rirr_vld && (rirr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= ENT_RESET;
            end else begin
                if (hit_rirr)
                    q[F_RIRR] <= rirr_val;
                if (hit_wr) begin
                    if (wr_hi) begin
                        q[63:32] <= wr_data;
                    end else begin
                        q[31:0]   <= wr_data;
                        q[F_RIRR] <= 1'b0;
                    end
                end
            end
        end

        assign ent_flat[i*64 +: 64]   = q;
        assign f_vector[i*8 +: 8]     = q[F_VEC_LSB +: 8];
        assign f_dlv_mode[i*3 +: 3]   = q[F_DLV_LSB +: 3];
        assign f_dest_mode[i]         = q[F_DMODE];
        assign f_polarity[i]          = q[F_POL];
        assign f_rirr[i]              = q[F_RIRR];
        assign f_trigger[i]           = q[F_TRIG];
        assign f_mask[i]              = q[F_MASK];
        assign f_dest[i*8 +: 8]       = q[F_DEST_LSB +: 8];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < PINS; i++) begin
            if (rd_idx == IDX_W'(i))
                rd_data = rd_hi ? ent_flat[i*64+32 +: 32] : ent_flat[i*64 +: 32];
        end
    end

endmodule

// File: rtl/ioredir_regfile.sv
module ioredir_regfile
    import ioredir_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] BASE     = 32'hFEC0_0000,
    parameter logic [31:0] WIN_LEN  = 32'h0000_0100,
    parameter logic [7:0]  SEL_OFS  = 8'h00,
    parameter logic [7:0]  WIN_OFS  = 8'h10,
    parameter int          PINS     = 24,
    parameter logic [7:0]  VER_CODE = 8'h11,
    parameter int          IDX_W    = $clog2(PINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              irr_upd_vld,
    input  logic [IDX_W-1:0]  irr_upd_idx,
    input  logic              irr_upd_val,
    output logic [PINS*8-1:0] ent_vector,
    output logic [PINS*3-1:0] ent_dlv_mode,
    output logic [PINS-1:0]   ent_dest_mode,
    output logic [PINS-1:0]   ent_polarity,
    output logic [PINS-1:0]   ent_rirr,
    output logic [PINS-1:0]   ent_trigger,
    output logic [PINS-1:0]   ent_mask,
    output logic [PINS*8-1:0] ent_dest,
    output logic              ent_wr_pulse,
    output logic [IDX_W-1:0]  ent_wr_idx
);

    localparam logic [31:0] VER_WORD = {8'h00, 8'(PINS - 1), 8'h00, VER_CODE};

    acc_kind_e        acc;
    tgt_kind_e        tgt;
    logic [31:0]      wdata_ext;
    logic [31:0]      size_mask;
    logic [IDX_W-1:0] tgt_idx;
    logic             tgt_hi;
    logic [31:0]      tbl_rd;
    logic [31:0]      rd_word;
    logic             ent_we;

    logic [7:0]       sel_q;
    logic [3:0]       id_q;
    logic [31:0]      rdata_q;
    logic             pulse_q;
    logic [IDX_W-1:0] pulse_idx_q;

    ioredir_decode #(
        .ADDR_W  (ADDR_W),
        .BASE    (BASE),
        .WIN_LEN (WIN_LEN),
        .SEL_OFS (SEL_OFS),
        .WIN_OFS (WIN_OFS)
    ) u_decode (
        .valid     (bus_valid),
        .write     (bus_write),
        .addr      (bus_addr),
        .size      (bus_size),
        .wdata     (bus_wdata),
        .acc       (acc),
        .wdata_ext (wdata_ext),
        .size_mask (size_mask)
    );

    ioredir_target #(
        .PINS  (PINS),
        .IDX_W (IDX_W)
    ) u_target (
        .sel (sel_q),
        .tgt (tgt),
        .idx (tgt_idx),
        .hi  (tgt_hi)
    );

    assign ent_we = (acc == ACC_WIN_WR) && (tgt == TGT_ENTRY);

    ioredir_table #(
        .PINS  (PINS),
        .IDX_W (IDX_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (ent_we),
        .wr_idx      (tgt_idx),
        .wr_hi       (tgt_hi),
        .wr_data     (wdata_ext),
        .rirr_vld    (irr_upd_vld),
        .rirr_idx    (irr_upd_idx),
        .rirr_val    (irr_upd_val),
        .rd_idx      (tgt_idx),
        .rd_hi       (tgt_hi),
        .rd_data     (tbl_rd),
        .f_vector    (ent_vector),
        .f_dlv_mode  (ent_dlv_mode),
        .f_dest_mode (ent_dest_mode),
        .f_polarity  (ent_polarity),
        .f_rirr      (ent_rirr),
        .f_trigger   (ent_trigger),
        .f_mask      (ent_mask),
        .f_dest      (ent_dest)
    );

    // read word selection
    always_comb begin
        rd_word = '0;
        unique case (acc)
            ACC_SEL_RD: rd_word = {24'h0, sel_q};
            ACC_WIN_RD: begin
                unique case (tgt)
                    TGT_ID, TGT_ARB: rd_word = {4'h0, id_q, 24'h0};
                    TGT_VER:         rd_word = VER_WORD;
                    TGT_ENTRY:       rd_word = tbl_rd;
                    default:         rd_word = 32'hFFFF_FFFF;
                endcase
            end
            default: rd_word = '0;
        endcase
    end

    // register state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q       <= '0;
            id_q        <= '0;
            rdata_q     <= '0;
            pulse_q     <= 1'b0;
            pulse_idx_q <= '0;
        end else begin
            pulse_q <= ent_we;
            if (ent_we)
                pulse_idx_q <= tgt_idx;
            unique case (acc)
                ACC_SEL_WR: sel_q <= wdata_ext[7:0];
                ACC_WIN_WR: begin
                    if (tgt == TGT_ID)
                        id_q <= wdata_ext[27:24];
                end
                ACC_SEL_RD, ACC_WIN_RD, ACC_ZERO_RD:
                    rdata_q <= rd_word & size_mask;
                default: ;
            endcase
        end
    end

    assign bus_rdata    = rdata_q;
    assign ent_wr_pulse = pulse_q;
    assign ent_wr_idx   = pulse_idx_q;

endmodule

// File: rtl/ioredir_chk.sv
module ioredir_chk #(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] BASE     = 32'hFEC0_0000,
    parameter logic [31:0] WIN_LEN  = 32'h0000_0100,
    parameter logic [7:0]  WIN_OFS  = 8'h10,
    parameter int          PINS     = 24,
    parameter logic [7:0]  VER_CODE = 8'h11,
    parameter int          IDX_W    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic [31:0]       bus_rdata,
    input logic [PINS-1:0]   ent_rirr,
    input logic              ent_wr_pulse,
    input logic [IDX_W-1:0]  ent_wr_idx,
    input logic [7:0]        sel_now
);

    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] LEN_A  = ADDR_W'(WIN_LEN);
    localparam logic [31:0] VER_EXP = {8'h00, 8'(PINS - 1), 8'h00, VER_CODE};

    logic             in_win;
    logic             win_acc;
    logic [7:0]       ent_raw;
    logic             low_wr;
    logic             low_wr_q;
    logic [IDX_W-1:0] low_idx_q;

    assign in_win  = (bus_addr >= BASE_A) && ((bus_addr - BASE_A) < LEN_A);
    assign win_acc = bus_valid && in_win && (bus_addr[7:0] == WIN_OFS);
    assign ent_raw = (sel_now - 8'h10) >> 1;
    assign low_wr  = win_acc && bus_write && (sel_now >= 8'h10) &&
                     !sel_now[0] && (ent_raw < 8'(PINS));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_wr_q  <= 1'b0;
            low_idx_q <= '0;
        end else begin
            low_wr_q  <= low_wr;
            low_idx_q <= ent_raw[IDX_W-1:0];
        end
    end

    AST_PULSE_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ent_wr_pulse |-> (ent_wr_idx < IDX_W'(PINS))); // R12

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata)); // R1

    AST_BYTE_READ_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && in_win && bus_size == 2'd0) |=> (bus_rdata[31:8] == 24'h0)); // R11

    AST_VERSION_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (win_acc && !bus_write && sel_now == 8'h01 && bus_size[1]) |=> (bus_rdata == VER_EXP)); // R4

    AST_LOW_WRITE_CLEARS_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
        low_wr_q |-> (ent_rirr[low_idx_q] == 1'b0)); // R8

endmodule

bind ioredir_regfile ioredir_chk #(
    .ADDR_W   (ADDR_W),
    .BASE     (BASE),
    .WIN_LEN  (WIN_LEN),
    .WIN_OFS  (WIN_OFS),
    .PINS     (PINS),
    .VER_CODE (VER_CODE),
    .IDX_W    (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .bus_addr     (bus_addr),
    .bus_size     (bus_size),
    .bus_rdata    (bus_rdata),
    .ent_rirr     (ent_rirr),
    .ent_wr_pulse (ent_wr_pulse),
    .ent_wr_idx   (ent_wr_idx),
    .sel_now      (sel_q)
);

// File: tb/ioredir_regfile_tb.sv
module ioredir_regfile_tb;

    localparam int          PINS  = 24;
    localparam int          IDX_W = 5;
    localparam logic [31:0] BASE  = 32'hFEC0_0000;
    localparam logic [31:0] WIN   = BASE + 32'h10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [31:0]       bus_addr = '0;
    logic [1:0]        bus_size = 2'd2;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irr_upd_vld = 1'b0;
    logic [IDX_W-1:0]  irr_upd_idx = '0;
    logic              irr_upd_val = 1'b0;
    logic [PINS*8-1:0] ent_vector;
    logic [PINS*3-1:0] ent_dlv_mode;
    logic [PINS-1:0]   ent_dest_mode;
    logic [PINS-1:0]   ent_polarity;
    logic [PINS-1:0]   ent_rirr;
    logic [PINS-1:0]   ent_trigger;
    logic [PINS-1:0]   ent_mask;
    logic [PINS*8-1:0] ent_dest;
    logic              ent_wr_pulse;
    logic [IDX_W-1:0]  ent_wr_idx;

    int   n_chk = 0;
    int   n_err = 0;
    logic seen_pulse;
    logic [IDX_W-1:0] seen_idx;

    always #5 clk = ~clk;

    ioredir_regfile u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_valid     (bus_valid),
        .bus_write     (bus_write),
        .bus_addr      (bus_addr),
        .bus_size      (bus_size),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .irr_upd_vld   (irr_upd_vld),
        .irr_upd_idx   (irr_upd_idx),
        .irr_upd_val   (irr_upd_val),
        .ent_vector    (ent_vector),
        .ent_dlv_mode  (ent_dlv_mode),
        .ent_dest_mode (ent_dest_mode),
        .ent_polarity  (ent_polarity),
        .ent_rirr      (ent_rirr),
        .ent_trigger   (ent_trigger),
        .ent_mask      (ent_mask),
        .ent_dest      (ent_dest),
        .ent_wr_pulse  (ent_wr_pulse),
        .ent_wr_idx    (ent_wr_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        seen_pulse = ent_wr_pulse;
        seen_idx   = ent_wr_idx;
    endtask

    task automatic bus_rd(input logic [31:0] a, input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = sz;
        @(negedge clk);
        bus_valid = 1'b0;
        d          = bus_rdata;
        seen_pulse = ent_wr_pulse;
    endtask

    task automatic ind_wr(input logic [7:0] s, input logic [31:0] d);
        bus_wr(BASE, 2'd2, {24'h0, s});
        bus_wr(WIN, 2'd2, d);
    endtask

    task automatic ind_rd(input logic [7:0] s, output logic [31:0] d);
        bus_wr(BASE, 2'd2, {24'h0, s});
        bus_rd(WIN, 2'd2, d);
    endtask

    task automatic rirr_drive(input logic [IDX_W-1:0] i, input logic v);
        @(negedge clk);
        irr_upd_vld = 1'b1; irr_upd_idx = i; irr_upd_val = v;
        @(negedge clk);
        irr_upd_vld = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R10 rdata after reset", bus_rdata, 32'h0);
        chk("R10 mask bits after reset", {8'h0, ent_mask}, 32'h00FF_FFFF);
        chk("R10 rirr after reset", {8'h0, ent_rirr}, 32'h0);
        bus_rd(BASE, 2'd2, d);
        chk("R10 select after reset", d, 32'h0);
        bus_rd(WIN, 2'd2, d);
        chk("R10 ID after reset", d, 32'h0);
        ind_rd(8'h10, d);
        chk("R10 entry0 low after reset", d, 32'h0001_0000);
        ind_rd(8'h3F, d);
        chk("R10 entry23 high after reset", d, 32'h0);
    endtask

    task automatic t_select;
        logic [31:0] d;
        bus_wr(BASE, 2'd2, 32'h1234_56A5);
        bus_rd(BASE, 2'd2, d);
        chk("R3 select keeps low byte", d, 32'h0000_00A5);
    endtask

    task automatic t_version;
        logic [31:0] d;
        ind_rd(8'h01, d);
        chk("R4 version word", d, 32'h0017_0011);
        bus_wr(WIN, 2'd2, 32'hFFFF_FFFF);
        bus_rd(WIN, 2'd2, d);
        chk("R4 version ignores writes", d, 32'h0017_0011);
    endtask

    task automatic t_id;
        logic [31:0] d;
        ind_wr(8'h00, 32'hF5A0_00FF);
        bus_rd(WIN, 2'd2, d);
        chk("R5 ID keeps bits 27:24", d, 32'h0500_0000);
        ind_rd(8'h02, d);
        chk("R5 arbitration index mirrors ID", d, 32'h0500_0000);
        bus_wr(WIN, 2'd2, 32'h0A00_0000);
        ind_rd(8'h00, d);
        chk("R5 arbitration write ignored", d, 32'h0500_0000);
    endtask

    task automatic t_entry;
        logic [31:0] d;
        ind_wr(8'h1A, 32'h0000_A3B1);
        chk("R12 pulse after low write", {31'h0, seen_pulse}, 32'h1);
        chk("R12 pulse index", {27'h0, seen_idx}, 32'd5);
        ind_wr(8'h1B, 32'h7700_0000);
        chk("R12 pulse index high write", {27'h0, seen_idx}, 32'd5);
        ind_rd(8'h1A, d);
        chk("R6 entry5 low readback", d, 32'h0000_A3B1);
        chk("R12 no pulse after read", {31'h0, seen_pulse}, 32'h0);
        ind_rd(8'h1B, d);
        chk("R6 entry5 high readback", d, 32'h7700_0000);
        chk("R13 vector", {24'h0, ent_vector[5*8 +: 8]}, 32'hB1);
        chk("R13 delivery mode", {29'h0, ent_dlv_mode[5*3 +: 3]}, 32'd3);
        chk("R13 dest mode/polarity/trigger/mask",
            {28'h0, ent_dest_mode[5], ent_polarity[5], ent_trigger[5], ent_mask[5]}, 32'b0110);
        chk("R13 destination", {24'h0, ent_dest[5*8 +: 8]}, 32'h77);
        ind_wr(8'h3F, 32'h1200_0000);
        chk("R12 last entry pulse index", {27'h0, seen_idx}, 32'd23);
        chk("R6 last entry destination", {24'h0, ent_dest[23*8 +: 8]}, 32'h12);
        chk("R6 other entries untouched", {31'h0, ent_mask[4]}, 32'h1);
    endtask

    task automatic t_oor;
        logic [31:0] d;
        ind_rd(8'h40, d);
        chk("R7 index 24 reads ones", d, 32'hFFFF_FFFF);
        ind_rd(8'hFF, d);
        chk("R7 select 0xFF reads ones", d, 32'hFFFF_FFFF);
        ind_rd(8'h07, d);
        chk("R7 select 0x07 reads ones", d, 32'hFFFF_FFFF);
        ind_wr(8'h40, 32'h0);
        chk("R7 no pulse for dropped write", {31'h0, seen_pulse}, 32'h0);
        ind_wr(8'h05, 32'h0);
        chk("R7 no pulse for reserved index", {31'h0, seen_pulse}, 32'h0);
        ind_rd(8'h00, d);
        chk("R7 reserved write leaves ID", d, 32'h0500_0000);
    endtask

    task automatic t_rirr;
        logic [31:0] d;
        rirr_drive(5'd5, 1'b1);
        chk("R9 rirr set by port", {31'h0, ent_rirr[5]}, 32'h1);
        ind_rd(8'h1A, d);
        chk("R9 rirr visible in entry", d, 32'h0000_E3B1);
        ind_wr(8'h1B, 32'h7700_0000);
        chk("R8 high write keeps rirr", {31'h0, ent_rirr[5]}, 32'h1);
        ind_wr(8'h1A, 32'h0000_E3B1);
        chk("R8 low write clears rirr", {31'h0, ent_rirr[5]}, 32'h0);
        rirr_drive(5'd5, 1'b1);
        rirr_drive(5'd5, 1'b0);
        chk("R9 rirr cleared by port", {31'h0, ent_rirr[5]}, 32'h0);
        rirr_drive(5'd5, 1'b1);
        bus_wr(BASE, 2'd2, 32'h1A);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = WIN; bus_size = 2'd2;
        bus_wdata = 32'h0000_A3B1;
        irr_upd_vld = 1'b1; irr_upd_idx = 5'd5; irr_upd_val = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; irr_upd_vld = 1'b0;
        chk("R9 software low write wins", {31'h0, ent_rirr[5]}, 32'h0);
        rirr_drive(5'd24, 1'b1);
        chk("R9 out of range update ignored", {8'h0, ent_rirr}, 32'h0);
    endtask

    task automatic t_size;
        logic [31:0] d;
        bus_wr(BASE, 2'd0, 32'h0000_01FF);
        bus_rd(BASE, 2'd2, d);
        chk("R11 byte write zero-extends", d, 32'h0000_00FF);
        bus_wr(BASE, 2'd2, 32'h1C);
        bus_wr(WIN, 2'd1, 32'hFFFF_1234);
        bus_rd(WIN, 2'd2, d);
        chk("R11 halfword write zero-extends", d, 32'h0000_1234);
        chk("R11 mask cleared by narrow write", {31'h0, ent_mask[6]}, 32'h0);
        bus_wr(BASE, 2'd2, 32'h01);
        bus_rd(WIN, 2'd0, d);
        chk("R11 byte read of version", d, 32'h11);
        bus_rd(WIN, 2'd1, d);
        chk("R11 halfword read of version", d, 32'h0011);
        bus_wr(BASE, 2'd2, 32'h00);
        bus_wr(WIN, 2'd0, 32'h0F00_0000);
        bus_rd(WIN, 2'd2, d);
        chk("R11 byte write to ID drops upper bits", d, 32'h0);
        bus_wr(BASE, 2'd3, 32'h0000_0033);
        bus_rd(BASE, 2'd3, d);
        chk("R11 size code 3 is word", d, 32'h33);
    endtask

    task automatic t_window;
        logic [31:0] d;
        bus_wr(BASE, 2'd2, 32'h1A);
        bus_wr(BASE + 32'h100, 2'd2, 32'h55);
        bus_rd(BASE, 2'd2, d);
        chk("R1 write past window ignored", d, 32'h1A);
        bus_rd(BASE + 32'h110, 2'd2, d);
        chk("R1 read past window leaves rdata", d, 32'h1A);
        bus_rd(BASE - 32'h10, 2'd2, d);
        chk("R1 read below window leaves rdata", d, 32'h1A);
        bus_rd(BASE + 32'h20, 2'd2, d);
        chk("R2 other offset reads zero", d, 32'h0);
        bus_wr(BASE + 32'h04, 2'd2, 32'h77);
        bus_rd(BASE, 2'd2, d);
        chk("R2 other offset write ignored", d, 32'h1A);
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_select();
                t_version();
                t_id();
                t_entry();
                t_oor();
                t_rirr();
                t_size();
                t_window();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule